// File: doc/BRIEF.md
# Video Bank Address Generator

This block converts a 14-bit address issued by the video controller into a physical fetch target. Each fetch goes either to the character ROM or to one 16 KB bank of main RAM. A two-bit bank selector, taken from a peripheral port, picks the RAM bank. The selector is inverted: the all-zero code reaches the top bank and the all-one code reaches the bottom bank.

The character ROM appears as a fixed 4 KB overlay inside the video address space, at video addresses 0x1000 to 0x1FFF. This overlay applies identically under every bank setting. When an address falls inside the overlay, the block raises a ROM-select flag and presents the low 12 address bits as the ROM offset.

The RAM address and the ROM offset are always driven, whether or not the overlay is hit. The downstream storage uses the flag to choose between them. All outputs are registered, so the result for an address appears exactly one clock after that address is presented.

A small source-state register records the fetch target. It has three states:

- `SRC_IDLE` is entered on reset.
- `SRC_RAM` is entered on any clock edge whose address lies outside the overlay (transition `GO_RAM`).
- `SRC_CHAR` is entered on any clock edge whose address lies inside it (transition `GO_CHAR`).

These transitions are taken from every state. Reset returns the register to `SRC_IDLE` (transition `GO_IDLE`).

Top module: `vid_bank_agen`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, the outputs become ram_addr = 0, rom_off = 0 and rom_sel = 0, and they stay there until the first edge with reset released.
- R2: Every output reflects the vaddr and bank_sel values sampled at the previous rising clock edge (one cycle of latency), and a new input is accepted on every cycle.
- R3: With bank_sel = 2'b00, ram_addr equals 0xC000 plus vaddr.
- R4: With bank_sel = 2'b01, ram_addr = 0x8000 + vaddr. With 2'b10, ram_addr = 0x4000 + vaddr. With 2'b11, ram_addr = vaddr. In every case ram_addr[15:14] is the bitwise inverse of bank_sel.
- R5: rom_sel is 1 exactly when vaddr lies in 0x1000–0x1FFF (vaddr[13:12] = 2'b01), for all four bank_sel values.
- R6: rom_off equals vaddr[11:0], whether or not rom_sel is set.
- R7: ram_addr[13:0] equals vaddr for every address, including addresses inside the ROM overlay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| vaddr | input | 14 | Address from the video controller |
| bank_sel | input | 2 | Bank selector from the peripheral port (inverted encoding) |
| ram_addr | output | 16 | Registered physical RAM address |
| rom_off | output | 12 | Registered character ROM offset |
| rom_sel | output | 1 | Registered flag: 1 selects the character ROM, 0 selects RAM |

## Verification
The following are checked by properties on every cycle after reset:

- the one-cycle relation between inputs and outputs;
- the inverted bank bits in the upper RAM address;
- the pass-through of the offset;
- the overlay flag against the previous address.

The bench's scenarios are needed for the rest:

- that the reset values hold while reset is asserted mid-run;
- that the exact window edges (0x0FFF, 0x1000, 0x1FFF, 0x2000) behave correctly under each bank;
- that back-to-back changes of bank and address land on the right cycle.

// File: rtl/vid_bank_pkg.sv
package vid_bank_pkg;
    localparam int VADDR_W = 14;
    localparam int BANK_W  = 2;
    localparam int ROM_W   = 12;
    localparam int PADDR_W = VADDR_W + BANK_W;
    localparam int TAG_W   = VADDR_W - ROM_W;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_CHAR = 2'd2
    } src_e;
endpackage

// File: rtl/vid_bank_win.sv
module vid_bank_win #(
    parameter int TAG_W   = 2,
    parameter int WIN_IDX = 1
) (
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_IDX);

    always_comb begin
        hit = (tag == WIN_TAG);
    end
endmodule

// File: rtl/vid_bank_base.sv
module vid_bank_base #(
    parameter int VADDR_W    = 14,
    parameter int BANK_W     = 2,
    parameter bit INVERT_SEL = 1'b1
) (
    input  logic [VADDR_W-1:0]        vaddr,
    input  logic [BANK_W-1:0]         bank_sel,
    output logic [VADDR_W+BANK_W-1:0] phys
);
    generate
        if (INVERT_SEL) begin : g_inv
            always_comb phys = {~bank_sel, vaddr};
        end else begin : g_dir
            always_comb phys = {bank_sel, vaddr};
        end
    endgenerate
endmodule

// File: rtl/vid_bank_agen.sv
module vid_bank_agen
    import vid_bank_pkg::*;
#(
    parameter int WIN_IDX = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic [PADDR_W-1:0] ram_addr,
    output logic [ROM_W-1:0]   rom_off,
    output logic               rom_sel
);
    logic               win_hit;
    logic [PADDR_W-1:0] phys_nxt;
    src_e               state_q, state_d;

    vid_bank_win #(.TAG_W(TAG_W), .WIN_IDX(WIN_IDX)) u_win (
        .tag (vaddr[VADDR_W-1:ROM_W]),
        .hit (win_hit)
    );

    vid_bank_base #(.VADDR_W(VADDR_W), .BANK_W(BANK_W), .INVERT_SEL(1'b1)) u_base (
        .vaddr    (vaddr),
        .bank_sel (bank_sel),
        .phys     (phys_nxt)
    );

    // Next-state selection: GO_CHAR / GO_RAM from any state
    always_comb begin
        state_d = SRC_IDLE;
        unique case (state_q)
            SRC_IDLE, SRC_RAM, SRC_CHAR: state_d = win_hit ? SRC_CHAR : SRC_RAM;
            default:                     state_d = SRC_IDLE;
        endcase
    end

    // State register (GO_IDLE on reset)
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    // Registered address outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
            rom_off  <= '0;
        end else begin
            ram_addr <= phys_nxt;
            rom_off  <= vaddr[ROM_W-1:0];
        end
    end

    always_comb rom_sel = (state_q == SRC_CHAR);

    // Assertions
    p_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (ram_addr == '0 && rom_off == '0 && !rom_sel));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ram_addr[VADDR_W-1:0] == $past(vaddr)));

    p_bank_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ram_addr[PADDR_W-1:VADDR_W] == ~$past(bank_sel)));

    p_overlay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rom_sel == ($past(vaddr[VADDR_W-1:ROM_W]) == TAG_W'(WIN_IDX))));

    p_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rom_off == $past(vaddr[ROM_W-1:0])));

    p_state_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (state_q != SRC_IDLE));
endmodule

// File: tb/vid_bank_agen_tb_top.sv
module vid_bank_agen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] vaddr = '0;
    logic [1:0]  bank_sel = '0;
    logic [15:0] ram_addr;
    logic [11:0] rom_off;
    logic        rom_sel;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [15:0] ram;
        logic [11:0] off;
        logic        sel;
        logic [1:0]  bank;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    vid_bank_agen dut_i (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .bank_sel(bank_sel),
        .ram_addr(ram_addr), .rom_off(rom_off), .rom_sel(rom_sel)
    );

    function automatic logic [15:0] bank_base(input logic [1:0] b);
        case (b)
            2'b00:   return 16'hC000;
            2'b01:   return 16'h8000;
            2'b10:   return 16'h4000;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present an address at the falling edge, push expected result
    task automatic drive(input logic [13:0] va, input logic [1:0] b);
        exp_t e;
        @(negedge clk);
        vaddr    = va;
        bank_sel = b;
        e.ram  = bank_base(b) | {2'b00, va};
        e.off  = va[11:0];
        e.sel  = (va >= 14'h1000) && (va < 14'h2000);
        e.bank = b;
        sb_q.push_back(e);
    endtask

    // Monitor: one cycle after the edge that captured the inputs (R2)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.bank == 2'b00)
                    chk(ram_addr == e.ram, "R3 R2 bank00 ram_addr", ram_addr, e.ram);
                else
                    chk(ram_addr == e.ram, "R4 R2 ram_addr", ram_addr, e.ram);
                chk(ram_addr[13:0] == e.ram[13:0], "R7 low bits", ram_addr, e.ram);
                chk(rom_sel == e.sel, "R5 rom_sel", rom_sel, e.sel);
                chk(rom_off == e.off, "R6 rom_off", rom_off, e.off);
            end
        end
    end

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [13:0] lf;
        repeat (3) @(posedge clk);
        #1;
        chk(ram_addr == 16'h0 && rom_off == 12'h0 && rom_sel == 1'b0, "R1 reset", {ram_addr, rom_off, 3'b0, rom_sel}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Window edges under each bank (R3 R4 R5 R6 R7)
        for (int b = 0; b < 4; b++) begin
            drive(14'h0000, 2'(b));
            drive(14'h0FFF, 2'(b));
            drive(14'h1000, 2'(b));
            drive(14'h1ABC, 2'(b));
            drive(14'h1FFF, 2'(b));
            drive(14'h2000, 2'(b));
            drive(14'h3FFF, 2'(b));
        end

        // Back-to-back bank and address changes (R2)
        lf = 14'h2D5;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[12:0], lf[13] ^ lf[12] ^ lf[11] ^ lf[1]};
            drive(lf, lf[7:6]);
        end
        @(negedge clk);
        @(negedge clk);

        // Mid-run reset (R1)
        vaddr = 14'h1234;
        bank_sel = 2'b00;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(ram_addr == 16'h0 && rom_off == 12'h0 && rom_sel == 1'b0, "R1 mid-run reset", {ram_addr, rom_off, 3'b0, rom_sel}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(14'h1001, 2'b10);
        drive(14'h0001, 2'b11);
        repeat (3) @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule